// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block is the arithmetic core of a simple load/store processor. A main controller supplies a two-bit operation class, and the instruction supplies its six-bit function field. A local decoder turns the pair into a four-bit operation code. A purely combinational datapath then applies that operation to two operands. It produces a result word and a flag that is set when the result is zero.

Loads and stores use the fixed add class to form addresses. Branches use the fixed subtract class and then read the zero flag to test whether two registers are equal. Register-to-register instructions use the decode class, where the function field picks the operation. The block has no clock and no state: its outputs follow its inputs within the same cycle.

Top module: `alu_unit`

## Requirements
- R1: With class input 00 the operation code is 0010 (add) and the result is the sum of the operands, whatever the function field holds.
- R2: With class input 01 the operation code is 0110 (subtract) and the result is first operand minus second operand, whatever the function field holds.
- R3: With class input 10 the function field (instruction bits 5..0) selects the operation code: 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (AND) and 100101 gives 0001 (OR).
- R4: With class input 10, any function field not listed in R3, R8 or R9 gives operation code 0010 and the sum of the operands.
- R5: Class input 11 yields the same operation code and result as class input 10 for every function field.
- R6: The operation code output only ever takes one of the values 0000, 0001, 0010, 0110, 0111 or 1100.
- R7: Add and subtract wrap modulo 2 to the power WIDTH. There is no overflow or carry indication.
- R8: Function field 101010 under the decode class gives operation code 0111. The result is 1 in bit 0 when the first operand is less than the second operand as a signed number, and 0 otherwise. All other result bits are 0.
- R9: Function field 100111 under the decode class gives operation code 1100, and the result is the bitwise NOT of (first operand OR second operand).
- R10: The zero output is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class | input | 2 | Operation class from the main controller |
| func_field | input | 6 | Function field, instruction bits 5..0 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The bench builds the block with its default 32-bit width. At that width the full-range cases become reachable: sums that wrap past the top bit, a signed compare where the most negative value meets a positive one, and results that are 0 even though both operands are nonzero.

The bench drives every class with several function fields. These include unlisted codes, so the fixed classes are shown to ignore the field and the fallback to add is exercised.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Shared operation codes, function-field constants and field widths for the
// arithmetic unit. Assumes a 6-bit function field and 2-bit operation class.
package alu_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNC_W  = 6;
    localparam int OPC_W   = 4;

    // Operation codes seen by the datapath
    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 4'b0000,
        OPC_OR  = 4'b0001,
        OPC_ADD = 4'b0010,
        OPC_SUB = 4'b0110,
        OPC_SLT = 4'b0111,
        OPC_NOR = 4'b1100
    } opc_e;

    // Operation classes issued by the main controller
    localparam logic [CLASS_W-1:0] CLS_ADD = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_SUB = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_FN  = 2'b10;
    localparam logic [CLASS_W-1:0] CLS_FN2 = 2'b11;

    // Function-field values understood under the decode class
    localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_NOR = 6'b100111;
    localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decoder.sv
// Module alu_op_decoder
// Two-level decode: the operation class forces add or subtract, or defers to
// the function field. Assumes class 11 behaves as 10 and unknown fields add.
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    input  logic [FUNC_W-1:0]  func,
    output opc_e               opc
);

    opc_e fn_opc;

    // Decode the function field into an operation code
    always_comb begin
        unique case (func)
            FN_ADD:  fn_opc = OPC_ADD;
            FN_SUB:  fn_opc = OPC_SUB;
            FN_AND:  fn_opc = OPC_AND;
            FN_OR:   fn_opc = OPC_OR;
            FN_NOR:  fn_opc = OPC_NOR;
            FN_SLT:  fn_opc = OPC_SLT;
            default: fn_opc = OPC_ADD;
        endcase
    end

    // Select between forced operations and the function-field decode
    always_comb begin
        unique case (cls)
            CLS_ADD: opc = OPC_ADD;
            CLS_SUB: opc = OPC_SUB;
            default: opc = fn_opc;
        endcase
    end

    // Guard the forced classes against the function decode
    always_comb begin
        if (!$isunknown(cls)) begin
            p_forced_add_r1: assert (cls != CLS_ADD || opc == OPC_ADD)
                else $error("class 00 did not give add");
            p_forced_sub_r2: assert (cls != CLS_SUB || opc == OPC_SUB)
                else $error("class 01 did not give subtract");
        end
    end

endmodule

// File: rtl/alu_datapath.sv
// Module alu_datapath
// Combinational operation unit of WIDTH bits. Assumes the code is one of
// the six legal values; any other code yields zero.
module alu_datapath
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  opc_e             opc,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic             less;

    // Shared arithmetic terms, wrapping modulo 2**WIDTH
    always_comb begin
        sum  = a + b;
        diff = a - b;
        less = $signed(a) < $signed(b);
    end

    // Apply the selected operation
    always_comb begin
        case (opc)
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_ADD: y = sum;
            OPC_SUB: y = diff;
            OPC_SLT: y = {{(WIDTH-1){1'b0}}, less};
            OPC_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    // A set-on-less-than result never uses the upper bits
    always_comb begin
        if (opc == OPC_SLT)
            p_slt_narrow_r8: assert (y[WIDTH-1:1] == '0)
                else $error("compare result has upper bits set");
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module alu_zero_detect
// Flags an all-zero word. Assumes WIDTH >= 1.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero
);

    // Reduce the word to a single zero indication
    always_comb begin
        is_zero = ~|word;
    end

endmodule

// File: rtl/alu_unit.sv
// Module alu_unit
// Top of the arithmetic unit: decoder, datapath and zero flag. Purely
// combinational; assumes the caller registers outputs as needed.
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [CLASS_W-1:0] alu_class,
    input  logic [FUNC_W-1:0]  func_field,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    output logic [OPC_W-1:0]   op_code,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);

    opc_e opc;

    alu_op_decoder u_dec (
        .cls  (alu_class),
        .func (func_field),
        .opc  (opc)
    );

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .opc (opc),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (result)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zd (
        .word    (result),
        .is_zero (zero)
    );

    // Expose the decoded code
    always_comb begin
        op_code = opc;
    end

    // Cross-check flag against result and legality of the code
    always_comb begin
        if (!$isunknown(result)) begin
            p_zero_match_r10: assert (zero == (result == '0))
                else $error("zero flag disagrees with result");
        end
        if (!$isunknown(op_code)) begin
            p_legal_code_r6: assert (op_code inside {4'b0000, 4'b0001, 4'b0010,
                                                     4'b0110, 4'b0111, 4'b1100})
                else $error("illegal operation code");
        end
    end

endmodule

// File: tb/test_alu_unit.sv
// Directed bench for alu_unit; each task drives one scenario and checks it.
module test_alu_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int WATCHDOG = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   alu_class;
    logic [5:0]   func_field;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [3:0]   op_code;
    logic [W-1:0] result;
    logic         zero;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_unit #(.WIDTH(W)) i_alu_unit (
        .alu_class  (alu_class),
        .func_field (func_field),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .op_code    (op_code),
        .result     (result),
        .zero       (zero)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a rising edge, observe at the following falling edge
    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        alu_class  = c;
        func_field = f;
        opnd_a     = a;
        opnd_b     = b;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [3:0] code,
                              input logic [W-1:0] val);
        chk({req, " code"}, W'(op_code), W'(code));
        chk({req, " result"}, result, val);
        chk({req, " zero"}, W'(zero), W'(val == '0));
    endtask

    task automatic t_idle;
        apply(2'b00, 6'b000000, '0, '0);
        expect_out("R10 idle", 4'b0010, '0);
    endtask

    task automatic t_r1_class_add;
        apply(2'b00, 6'b100010, 32'd1000, 32'd24);
        expect_out("R1 add ignores func", 4'b0010, 32'd1024);
        apply(2'b00, 6'b101010, 32'h0000_0100, 32'hFFFF_FFFC);
        expect_out("R1 add negative offset", 4'b0010, 32'h0000_00FC);
    endtask

    task automatic t_r2_class_sub;
        apply(2'b01, 6'b100100, 32'd77, 32'd77);
        expect_out("R2 equal operands", 4'b0110, '0);
        apply(2'b01, 6'b100000, 32'd5, 32'd9);
        expect_out("R2 unequal operands", 4'b0110, 32'hFFFF_FFFC);
    endtask

    task automatic t_r3_func;
        apply(2'b10, 6'b100000, 32'd3, 32'd4);
        expect_out("R3 add", 4'b0010, 32'd7);
        apply(2'b10, 6'b100010, 32'd10, 32'd3);
        expect_out("R3 sub", 4'b0110, 32'd7);
        apply(2'b10, 6'b100100, 32'hF0F0_FF00, 32'h0FF0_F0F0);
        expect_out("R3 and", 4'b0000, 32'h00F0_F000);
        apply(2'b10, 6'b100101, 32'hF000_000F, 32'h0F00_00F0);
        expect_out("R3 or", 4'b0001, 32'hFF00_00FF);
        apply(2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555);
        expect_out("R3 and disjoint", 4'b0000, '0);
    endtask

    task automatic t_r4_unknown;
        apply(2'b10, 6'b000000, 32'd20, 32'd22);
        expect_out("R4 unknown 000000", 4'b0010, 32'd42);
        apply(2'b10, 6'b111111, 32'd1, 32'd1);
        expect_out("R4 unknown 111111", 4'b0010, 32'd2);
        apply(2'b10, 6'b100011, 32'd9, 32'd1);
        expect_out("R4 unknown 100011", 4'b0010, 32'd10);
    endtask

    task automatic t_r5_class11;
        apply(2'b11, 6'b100010, 32'd10, 32'd3);
        expect_out("R5 sub", 4'b0110, 32'd7);
        apply(2'b11, 6'b101010, 32'hFFFF_FFFF, 32'd0);
        expect_out("R5 slt", 4'b0111, 32'd1);
        apply(2'b11, 6'b010101, 32'd4, 32'd4);
        expect_out("R5 unknown", 4'b0010, 32'd8);
    endtask

    task automatic t_r7_wrap;
        apply(2'b00, 6'b0, 32'hFFFF_FFFF, 32'd1);
        expect_out("R7 add wrap", 4'b0010, '0);
        apply(2'b01, 6'b0, 32'h8000_0000, 32'd1);
        expect_out("R7 sub wrap", 4'b0110, 32'h7FFF_FFFF);
    endtask

    task automatic t_r8_slt;
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'd1);
        expect_out("R8 most negative", 4'b0111, 32'd1);
        apply(2'b10, 6'b101010, 32'd1, 32'h8000_0000);
        expect_out("R8 positive vs negative", 4'b0111, 32'd0);
        apply(2'b10, 6'b101010, 32'd5, 32'd5);
        expect_out("R8 equal", 4'b0111, 32'd0);
        apply(2'b10, 6'b101010, 32'd2, 32'd3);
        expect_out("R8 small positive", 4'b0111, 32'd1);
    endtask

    task automatic t_r9_nor;
        apply(2'b10, 6'b100111, 32'hF0F0_0000, 32'h0000_0F0F);
        expect_out("R9 nor", 4'b1100, 32'h0F0F_F0F0);
        apply(2'b10, 6'b100111, 32'hFFFF_0000, 32'h0000_FFFF);
        expect_out("R9 nor all ones", 4'b1100, '0);
    endtask

    initial begin
        alu_class  = '0;
        func_field = '0;
        opnd_a     = '0;
        opnd_b     = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_r1_class_add();
        t_r2_class_sub();
        t_r3_func();
        t_r4_unknown();
        t_r5_class11();
        t_r7_wrap();
        t_r8_slt();
        t_r9_nor();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule